// File: doc/BRIEF.md
# GPIO configuration lock-and-commit guard

This block is the register-bank front end that holds the pin-configuration state of one 8-bit general-purpose I/O port. Four configuration registers live here: alternate-function select, pull-up enable, pull-down enable and digital enable. A small set of pins on some ports is reserved by default for a debug port or for the non-maskable interrupt input. On those pins, a stray software write must not be able to take the pin away from its default function.

Each protected bit of a configuration register is guarded by two things. The first is a port-wide lock, which opens only when a 32-bit key is written. The second is a per-pin commit mask, which can be loaded only while the lock is open. A protected bit accepts a write only when the port is unlocked and its commit bit is set. A write that does not meet both conditions is dropped and raises no error. Unprotected bits accept writes at any time. A parameter selects which pins a given port protects.

Software reaches the block over a simple synchronous bus with address, write enable, write data and read data. Reads are combinational from the current register state. The four configuration values also leave the block as pin-control outputs.

Top module: `gpio_cfg_guard`

## Requirements
- R1: After reset, the lock reads 1 (locked), the commit mask reads 0, the pull-up and pull-down registers read 0, and the alternate-function and digital-enable registers read 1 on the protected bits and 0 on every other bit.
- R2: Writing 0x4C4F434B to the lock register (address 4) unlocks the port, and the lock then reads 0.
- R3: Writing any other value to the lock register locks the port, and the lock then reads 1.
- R4: A write to the commit register (address 5) changes it only while the port is unlocked. Otherwise the write has no effect.
- R5: Unprotected bits of the configuration registers take every write, whatever the lock and commit state. The addresses are 0 for alternate function, 1 for pull-up, 2 for pull-down and 3 for digital enable.
- R6: While the port is locked, a write leaves every protected bit of the configuration registers unchanged, even when its commit bit is set.
- R7: While the port is unlocked, a protected bit whose commit bit is 0 keeps its value on a write.
- R8: While the port is unlocked, a protected bit whose commit bit is 1 takes the written value on the next clock edge.
- R9: The protection parameter selects the protected bits. The value 0 protects bits 3:0, the value 1 protects bit 7, and the value 2 protects bit 0.
- R10: Addresses 6 and 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| we | input | 1 | Write strobe for the current cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| altfn_o | output | 8 | Alternate-function select per pin |
| pullup_o | output | 8 | Pull-up enable per pin |
| pulldn_o | output | 8 | Pull-down enable per pin |
| digen_o | output | 8 | Digital enable per pin |

## Verification
The assertions assume that addr, we and wdata are free of X and do not change in the middle of a cycle. They also assume that a write cycle is one address with one data word, and that reset is held for at least one clock edge before the bus is used. The stimulus drives the bus only a short time after a rising edge and holds it until the next edge. It keeps we low except on the single cycle of each write, and it releases reset only after several edges. The same bus feeds three copies of the block, one for each protection choice, so each lock, commit and write pattern is checked against all three masks.

// File: rtl/gpio_guard_pkg.sv
package gpio_guard_pkg;

    localparam int            ADDR_W     = 3;
    localparam int            DATA_W     = 32;
    localparam int            NCFG       = 4;
    localparam logic [31:0]   UNLOCK_KEY = 32'h4C4F434B;

    typedef enum logic [1:0] {
        PROT_DBG4 = 2'd0,
        PROT_HI   = 2'd1,
        PROT_LO   = 2'd2
    } prot_sel_e;

    typedef enum logic [ADDR_W-1:0] {
        A_ALTFN  = 3'd0,
        A_PULLUP = 3'd1,
        A_PULLDN = 3'd2,
        A_DIGEN  = 3'd3,
        A_LOCK   = 3'd4,
        A_COMMIT = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic                  we;
        logic [ADDR_W-1:0]     addr;
        logic [DATA_W-1:0]     data;
    } bus_wr_t;

    function automatic logic [31:0] prot_mask(prot_sel_e sel);
        case (sel)
            PROT_DBG4: return 32'h0000_000F;
            PROT_HI:   return 32'h0000_0080;
            PROT_LO:   return 32'h0000_0001;
            default:   return 32'h0000_0000;
        endcase
    endfunction

    // Alternate-function (index 0) and digital-enable (index 3) start with
    // the protected pins in their special function.
    function automatic logic [31:0] cfg_reset(int idx, prot_sel_e sel);
        if (idx == 0 || idx == 3) return prot_mask(sel);
        return 32'h0;
    endfunction

    function automatic logic [31:0] merge_bits(logic [31:0] old_v,
                                               logic [31:0] new_v,
                                               logic [31:0] mask);
        return (old_v & ~mask) | (new_v & mask);
    endfunction

endpackage

// File: rtl/gpio_lock_ctrl.sv
module gpio_lock_ctrl
    import gpio_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lock,
    input  logic [DATA_W-1:0] wdata,
    output logic              unlocked_o
);
    logic key_match;

    always_comb key_match = (wdata == UNLOCK_KEY);

    always_ff @(posedge clk) begin
        if (rst)          unlocked_o <= 1'b0;
        else if (wr_lock) unlocked_o <= key_match;
    end
endmodule

// File: rtl/gpio_commit_reg.sv
module gpio_commit_reg #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_commit,
    input  logic            unlocked,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] commit_o
);
    logic load;

    always_comb load = wr_commit && unlocked;

    always_ff @(posedge clk) begin
        if (rst)       commit_o <= '0;
        else if (load) commit_o <= wdata;
    end
endmodule

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg
    import gpio_guard_pkg::*;
#(
    parameter int              PINS    = 8,
    parameter logic [PINS-1:0] RST_VAL = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [PINS-1:0] wdata,
    input  logic [PINS-1:0] wr_mask,
    output logic [PINS-1:0] q
);
    logic [31:0] merged;

    always_comb merged = merge_bits(32'(q), 32'(wdata), 32'(wr_mask));

    always_ff @(posedge clk) begin
        if (rst)        q <= RST_VAL;
        else if (wr_en) q <= merged[PINS-1:0];
    end
endmodule

// File: rtl/gpio_cfg_guard.sv
module gpio_cfg_guard
    import gpio_guard_pkg::*;
#(
    parameter int        PINS = 8,
    parameter prot_sel_e PROT = PROT_DBG4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [PINS-1:0]   altfn_o,
    output logic [PINS-1:0]   pullup_o,
    output logic [PINS-1:0]   pulldn_o,
    output logic [PINS-1:0]   digen_o
);
    localparam logic [31:0]     PMASK32 = prot_mask(PROT);
    localparam logic [PINS-1:0] PMASK   = PMASK32[PINS-1:0];

    bus_wr_t                    bus;
    logic                       unlocked;
    logic [PINS-1:0]            commit_q;
    logic [PINS-1:0]            wr_mask;
    logic [NCFG-1:0][PINS-1:0]  cfg_q;

    always_comb begin
        bus.we   = we;
        bus.addr = addr;
        bus.data = wdata;
    end

    // A protected bit opens only with the lock open and its commit bit set.
    always_comb wr_mask = ~PMASK | (commit_q & {PINS{unlocked}});

    gpio_lock_ctrl u_lock (
        .clk        (clk),
        .rst        (rst),
        .wr_lock    (bus.we && bus.addr == A_LOCK),
        .wdata      (bus.data),
        .unlocked_o (unlocked)
    );

    gpio_commit_reg #(.PINS(PINS)) u_commit (
        .clk       (clk),
        .rst       (rst),
        .wr_commit (bus.we && bus.addr == A_COMMIT),
        .unlocked  (unlocked),
        .wdata     (bus.data[PINS-1:0]),
        .commit_o  (commit_q)
    );

    for (genvar k = 0; k < NCFG; k++) begin : g_cfg
        localparam logic [31:0] RV32 = cfg_reset(k, PROT);
        gpio_cfg_reg #(
            .PINS    (PINS),
            .RST_VAL (RV32[PINS-1:0])
        ) u_cfg (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (bus.we && bus.addr == ADDR_W'(k)),
            .wdata   (bus.data[PINS-1:0]),
            .wr_mask (wr_mask),
            .q       (cfg_q[k])
        );
    end

    always_comb begin
        rdata = '0;
        case (bus.addr)
            A_ALTFN, A_PULLUP, A_PULLDN, A_DIGEN:
                rdata[PINS-1:0] = cfg_q[bus.addr[1:0]];
            A_LOCK:   rdata[0]        = ~unlocked;
            A_COMMIT: rdata[PINS-1:0] = commit_q;
            default:  rdata = '0;
        endcase
    end

    assign altfn_o  = cfg_q[0];
    assign pullup_o = cfg_q[1];
    assign pulldn_o = cfg_q[2];
    assign digen_o  = cfg_q[3];
endmodule

// File: rtl/gpio_cfg_guard_chk.sv
module gpio_cfg_guard_chk
    import gpio_guard_pkg::*;
#(
    parameter int        PINS = 8,
    parameter prot_sel_e PROT = PROT_DBG4
) (
    input logic                      clk,
    input logic                      rst,
    input logic [ADDR_W-1:0]         addr,
    input logic                      we,
    input logic [DATA_W-1:0]         wdata,
    input logic                      unlocked,
    input logic [PINS-1:0]           commit_q,
    input logic [NCFG-1:0][PINS-1:0] cfg_q
);
    localparam logic [31:0]     PM32  = prot_mask(PROT);
    localparam logic [PINS-1:0] PMASK = PM32[PINS-1:0];

    p_key_opens_r2: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_LOCK && wdata == UNLOCK_KEY) |=> unlocked);

    p_bad_key_closes_r3: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_LOCK && wdata != UNLOCK_KEY) |=> !unlocked);

    p_commit_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        !unlocked |=> $stable(commit_q));

    for (genvar k = 0; k < NCFG; k++) begin : g_p
        p_unprot_write_r5: assert property (@(posedge clk) disable iff (rst)
            (we && addr == ADDR_W'(k)) |=>
                ((cfg_q[k] ^ $past(wdata[PINS-1:0])) & ~PMASK) == '0);

        p_locked_hold_r6: assert property (@(posedge clk) disable iff (rst)
            (we && addr == ADDR_W'(k) && !unlocked) |=>
                ((cfg_q[k] ^ $past(cfg_q[k])) & PMASK) == '0);

        p_uncommitted_hold_r7: assert property (@(posedge clk) disable iff (rst)
            (we && addr == ADDR_W'(k) && unlocked) |=>
                ((cfg_q[k] ^ $past(cfg_q[k])) & PMASK & ~$past(commit_q)) == '0);

        p_committed_take_r8: assert property (@(posedge clk) disable iff (rst)
            (we && addr == ADDR_W'(k) && unlocked) |=>
                ((cfg_q[k] ^ $past(wdata[PINS-1:0])) & PMASK & $past(commit_q)) == '0);

        p_idle_stable_r10: assert property (@(posedge clk) disable iff (rst)
            !(we && addr == ADDR_W'(k)) |=> $stable(cfg_q[k]));
    end
endmodule

bind gpio_cfg_guard gpio_cfg_guard_chk #(.PINS(PINS), .PROT(PROT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .we       (we),
    .wdata    (wdata),
    .unlocked (unlocked),
    .commit_q (commit_q),
    .cfg_q    (cfg_q)
);

// File: tb/tb_gpio_cfg_guard.sv
`timescale 1ns/1ps
module tb_gpio_cfg_guard;
    import gpio_guard_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rd [3];
    logic [7:0]  alt_a, pu_a, pd_a, de_a;
    logic [7:0]  alt_b, pu_b, pd_b, de_b;
    logic [7:0]  alt_c, pu_c, pd_c, de_c;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    gpio_cfg_guard #(.PINS(8), .PROT(PROT_DBG4)) dut (
        .clk(clk), .rst(rst), .addr(addr), .we(we), .wdata(wdata), .rdata(rd[0]),
        .altfn_o(alt_a), .pullup_o(pu_a), .pulldn_o(pd_a), .digen_o(de_a));
    gpio_cfg_guard #(.PINS(8), .PROT(PROT_HI)) dut_hi (
        .clk(clk), .rst(rst), .addr(addr), .we(we), .wdata(wdata), .rdata(rd[1]),
        .altfn_o(alt_b), .pullup_o(pu_b), .pulldn_o(pd_b), .digen_o(de_b));
    gpio_cfg_guard #(.PINS(8), .PROT(PROT_LO)) dut_lo (
        .clk(clk), .rst(rst), .addr(addr), .we(we), .wdata(wdata), .rdata(rd[2]),
        .altfn_o(alt_c), .pullup_o(pu_c), .pulldn_o(pd_c), .digen_o(de_c));

    // Reference state kept from the requirements (R9 masks per variant).
    logic [7:0] pm [3] = '{8'h0F, 8'h80, 8'h01};
    bit         m_unl [3];
    logic [7:0] m_com [3];
    logic [7:0] m_cfg [3][4];

    typedef struct {
        logic [2:0]  a;
        logic [31:0] exp [3];
        string       tag;
    } item_t;
    item_t exp_q [$];

    task automatic model_reset();
        for (int v = 0; v < 3; v++) begin
            m_unl[v] = 1'b0;
            m_com[v] = 8'h00;
            m_cfg[v][0] = pm[v];
            m_cfg[v][1] = 8'h00;
            m_cfg[v][2] = 8'h00;
            m_cfg[v][3] = pm[v];
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        addr = a; we = 1'b1; wdata = d;
        for (int v = 0; v < 3; v++) begin
            logic [7:0] m;
            m = ~pm[v] | (m_com[v] & {8{m_unl[v]}});
            if (a < 3'd4)
                m_cfg[v][a[1:0]] = (m_cfg[v][a[1:0]] & ~m) | (d[7:0] & m);
            else if (a == 3'd4)
                m_unl[v] = (d == 32'h4C4F434B);
            else if (a == 3'd5 && m_unl[v])
                m_com[v] = d[7:0];
        end
    endtask

    task automatic rd_chk(input logic [2:0] a, input string tag);
        item_t it;
        @(posedge clk); #1;
        addr = a; we = 1'b0; wdata = '0;
        it.a = a;
        it.tag = tag;
        for (int v = 0; v < 3; v++) begin
            if (a < 3'd4)       it.exp[v] = {24'h0, m_cfg[v][a[1:0]]};
            else if (a == 3'd4) it.exp[v] = {31'h0, ~m_unl[v]};
            else if (a == 3'd5) it.exp[v] = {24'h0, m_com[v]};
            else                it.exp[v] = 32'h0;
        end
        exp_q.push_back(it);
    endtask

    task automatic rd_all(input string tag);
        for (int a = 0; a < 6; a++) rd_chk(3'(a), tag);
    endtask

    // Monitor: compares at the falling edge, away from register updates.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                for (int v = 0; v < 3; v++) begin
                    checks++;
                    if (rd[v] !== it.exp[v]) begin
                        errors++;
                        $display("FAIL %s variant %0d addr %0d: actual %h expected %h",
                                 it.tag, v, it.a, rd[v], it.exp[v]);
                    end
                end
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        rd_all("R1 reset R9");
        // R5/R6: locked; only unprotected bits move
        wr(3'd0, 32'h0000_0000); rd_chk(3'd0, "R5 R6 altfn locked");
        wr(3'd1, 32'h0000_00FF); rd_chk(3'd1, "R5 pullup locked");
        wr(3'd3, 32'h0000_0000); rd_chk(3'd3, "R6 digen locked");
        // R4: commit ignored while locked
        wr(3'd5, 32'h0000_00FF); rd_chk(3'd5, "R4 commit locked");
        // R2: key opens
        wr(3'd4, 32'h4C4F434B); rd_chk(3'd4, "R2 unlock");
        // R7: unlocked, no commit bits
        wr(3'd3, 32'h0000_0000); rd_chk(3'd3, "R7 no commit");
        // R8: partial commit
        wr(3'd5, 32'h0000_0005); rd_chk(3'd5, "R4 commit unlocked");
        wr(3'd0, 32'h0000_0000); rd_chk(3'd0, "R8 R7 partial commit");
        wr(3'd5, 32'h0000_00FF);
        wr(3'd2, 32'h0000_00FF); rd_chk(3'd2, "R8 full commit pulldn");
        wr(3'd3, 32'h0000_0000); rd_chk(3'd3, "R8 full commit digen");
        // R10: unmapped addresses
        wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'hFFFF_FFFF);
        rd_chk(3'd6, "R10 read 6"); rd_chk(3'd7, "R10 read 7");
        rd_all("R10 no side effect");
        // R3: wrong key relocks
        wr(3'd4, 32'h4C4F434A); rd_chk(3'd4, "R3 relock");
        wr(3'd0, 32'h0000_00FF); rd_chk(3'd0, "R6 locked with commit");
        wr(3'd1, 32'h0000_0000); rd_chk(3'd1, "R6 R5 pullup locked");
        wr(3'd5, 32'h0000_0000); rd_chk(3'd5, "R4 commit frozen");
        // R2 again, then R8 writes back to special function
        wr(3'd4, 32'h4C4F434B);
        wr(3'd3, 32'h0000_00FF); rd_chk(3'd3, "R8 restore digen");
        wr(3'd4, 32'h0000_0000); rd_chk(3'd4, "R3 zero relocks");
        // R1: reset mid-run returns everything to defaults
        @(posedge clk); #1 rst = 1'b1; we = 1'b0;
        @(posedge clk); #1 rst = 1'b0;
        model_reset();
        rd_all("R1 second reset");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule